// File: doc/BRIEF.md
# Bus Clock Source Switch Sequencer

This block moves the transfer-bus clock of a two-channel disk controller from one source to the other without corrupting either channel. The two sources are a locally generated PLL clock and the host bus clock. A requester raises a one-cycle request with an 8-bit source code. Code 0x21 asks for the PLL clock and code 0x23 asks for the host bus clock. The requester decides which source is needed: the PLL clock for write transfers or when the host bus runs at 66 MHz, the host bus clock otherwise. The block takes a request only when the partner channel reports idle, the code is one of the two known values, and the code names a source other than the one in use.

An accepted request runs a fixed five-step sequence, and each step lasts `HOLD_CYCLES` clocks:

1. Both channels are disconnected (tristated) from the bus.
2. The clock select takes the new value and the channel reset is asserted.
3. Each channel state machine gets a one-cycle reset pulse.
4. The channel reset is released.
5. Both channels are reconnected.

A one-cycle done flag follows the last step. The glitch-free clock multiplexer is outside this block; it only consumes `clk_sel_o`.

Top module: `clk_src_switch`

## Requirements
- R1: After reset, `clk_sel_o` is 0 (host bus clock), and `bus_tri_o`, `chan_rst_o`, `sm_rst_o`, `busy_o` and `done_o` are all 0.
- R2: Code 0x21 selects the PLL clock (`clk_sel_o` = 1) and code 0x23 selects the host bus clock (`clk_sel_o` = 0). A request with any other code is ignored: `busy_o` stays 0 and `clk_sel_o` is unchanged.
- R3: A request made while `pair_idle_i` is 0 is ignored.
- R4: A request whose code names the source already in use is ignored.
- R5: The accepted sequence has a fixed order:
  - isolate: both `bus_tri_o` bits are 1;
  - select: the new `clk_sel_o` value appears, `chan_rst_o` is 1 and the tristate is held;
  - state-machine reset: both `sm_rst_o` bits are 1 for the first cycle of the step only, with `chan_rst_o` still 1;
  - release: `chan_rst_o` is 0 and the tristate is still held;
  - reconnect: `bus_tri_o` is 0.
- R6: Each of the five steps lasts exactly `HOLD_CYCLES` clocks (default 4). The isolate step begins in the cycle after the accepting clock edge.
- R7: `busy_o` is 1 from the cycle after acceptance until the reconnect step ends. Requests that arrive while `busy_o` is 1 are ignored.
- R8: `clk_sel_o` changes only at the start of the select step.
- R9: `done_o` is 1 for exactly one cycle, the cycle right after the reconnect step, and `busy_o` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Switch request, sampled on each rising edge |
| src_code_i | input | 8 | Requested source code: 0x21 for the PLL clock, 0x23 for the host bus clock |
| pair_idle_i | input | 1 | Partner channel is idle |
| bus_tri_o | output | NUM_CH | Per-channel bus isolation enable |
| clk_sel_o | output | 1 | Current clock source: 1 for the PLL clock, 0 for the host bus clock |
| chan_rst_o | output | 1 | Channel logic reset |
| sm_rst_o | output | NUM_CH | Per-channel state-machine reset pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The assertions check the orderings that hold on every cycle:
- the channel reset is only asserted while the bus is isolated;
- state-machine reset pulses occur only under the channel reset and last one cycle;
- the clock select moves only when the select step is entered;
- the step counter stays below its limit;
- done is a one-cycle pulse with busy low.

Only the bench scenarios can show the rest: the exact cycle on which each step begins and ends, and the rejection of a request because of a matching source, an unknown code, a busy partner or a running sequence. These depend on the stimulus history rather than on a relation between neighbouring signals.

// File: rtl/csw_pkg.sv
package csw_pkg;

  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] SRC_CODE_PLL  = 8'h21;
  localparam logic [CODE_W-1:0] SRC_CODE_HOST = 8'h23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISOLATE,
    ST_SELECT,
    ST_SMRST,
    ST_RELEASE,
    ST_RECONNECT
  } seq_state_e;

  // True for the two recognised source codes.
  function automatic logic code_known(input logic [CODE_W-1:0] code);
    return (code == SRC_CODE_PLL) || (code == SRC_CODE_HOST);
  endfunction

  // Select value for a code: 1 means the PLL clock.
  function automatic logic code_to_sel(input logic [CODE_W-1:0] code);
    return code == SRC_CODE_PLL;
  endfunction

  // Fixed step order of the switch sequence.
  function automatic seq_state_e next_step(input seq_state_e s);
    case (s)
      ST_ISOLATE: return ST_SELECT;
      ST_SELECT:  return ST_SMRST;
      ST_SMRST:   return ST_RELEASE;
      ST_RELEASE: return ST_RECONNECT;
      default:    return ST_IDLE;
    endcase
  endfunction

  // The bus stays isolated from the isolate step through the release step.
  function automatic logic step_isolates(input seq_state_e s);
    return (s == ST_ISOLATE) || (s == ST_SELECT) ||
           (s == ST_SMRST) || (s == ST_RELEASE);
  endfunction

endpackage

// File: rtl/csw_step_timer.sv
module csw_step_timer #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign first_o = run_i && (cnt_q == '0);
  assign last_o  = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run_i || last_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // R6: the count never runs past the step length.
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

endmodule

// File: rtl/csw_src_tracker.sv
module csw_src_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic req_sel_i,
  input  logic commit_i,
  output logic cur_sel_o,
  output logic differs_o
);
  logic cur_q;
  logic pend_q;

  assign cur_sel_o = cur_q;
  assign differs_o = req_sel_i != cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (capture_i) pend_q <= req_sel_i;
      if (commit_i)  cur_q  <= pend_q;
    end
  end

  // R8: the current source moves only when the select step is entered.
  p_sel_moves_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> $past(commit_i));

endmodule

// File: rtl/csw_chan_drive.sv
module csw_chan_drive
  import csw_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       step_first_i,
  output logic       tri_o,
  output logic       smrst_o
);
  assign tri_o   = step_isolates(state_i);
  assign smrst_o = (state_i == ST_SMRST) && step_first_i;
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import csw_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [7:0]        src_code_i,
  input  logic              pair_idle_i,
  output logic [NUM_CH-1:0] bus_tri_o,
  output logic              clk_sel_o,
  output logic              chan_rst_o,
  output logic [NUM_CH-1:0] sm_rst_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e state_q;
  logic       step_first;
  logic       step_last;
  logic       cur_sel;
  logic       sel_differs;
  logic       accept;
  logic       enter_select;
  logic       seq_end;
  logic       done_q;

  assign accept = req_i && pair_idle_i && (state_q == ST_IDLE) &&
                  code_known(src_code_i) && sel_differs;
  assign enter_select = (state_q == ST_ISOLATE) && step_last;
  assign seq_end      = (state_q == ST_RECONNECT) && step_last;

  csw_step_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state_q != ST_IDLE),
    .first_o (step_first),
    .last_o  (step_last)
  );

  csw_src_tracker u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (accept),
    .req_sel_i (code_to_sel(src_code_i)),
    .commit_i  (enter_select),
    .cur_sel_o (cur_sel),
    .differs_o (sel_differs)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    csw_chan_drive u_drv (
      .state_i      (state_q),
      .step_first_i (step_first),
      .tri_o        (bus_tri_o[ch]),
      .smrst_o      (sm_rst_o[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= seq_end;
      if (state_q == ST_IDLE) begin
        if (accept) state_q <= ST_ISOLATE;
      end else if (step_last) begin
        state_q <= next_step(state_q);
      end
    end
  end

  assign clk_sel_o  = cur_sel;
  assign chan_rst_o = (state_q == ST_SELECT) || (state_q == ST_SMRST);
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = done_q;

  // R5: channel reset only while every channel is isolated.
  p_rst_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_o |-> (&bus_tri_o));

  // R5: state-machine pulses only under channel reset, one cycle wide.
  p_smrst_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sm_rst_o) |-> chan_rst_o);
  p_smrst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sm_rst_o) |=> !(|sm_rst_o));

  // R7: once running, busy holds until the reconnect step ends.
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !seq_end) |=> busy_o);

  // R9: done is a single-cycle flag with busy low.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/clk_src_switch_tb.sv
module clk_src_switch_tb;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] src_code_i = 8'h00;
  logic       pair_idle_i = 1'b1;
  logic [1:0] bus_tri_o;
  logic       clk_sel_o;
  logic       chan_rst_o;
  logic [1:0] sm_rst_o;
  logic       busy_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clk_src_switch #(.NUM_CH(2), .HOLD_CYCLES(H)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .src_code_i  (src_code_i),
    .pair_idle_i (pair_idle_i),
    .bus_tri_o   (bus_tri_o),
    .clk_sel_o   (clk_sel_o),
    .chan_rst_o  (chan_rst_o),
    .sm_rst_o    (sm_rst_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  // Port bundle, MSB first: tri[1:0], chan_rst, smrst[1:0], busy, done, sel.
  function automatic logic [7:0] observed();
    return {bus_tri_o, chan_rst_o, sm_rst_o, busy_o, done_o, clk_sel_o};
  endfunction

  // Expected bundle k cycles after the accepting edge.
  function automatic logic [7:0] expect_at(int k, logic old_sel, logic new_sel);
    logic       iso;
    logic       crst;
    logic       smr;
    logic       bsy;
    logic       dn;
    logic       sel;
    int         step;
    step = (k - 1) / H;
    bsy  = (k >= 1) && (k <= 5 * H);
    iso  = bsy && (step <= 3);
    crst = bsy && (step == 1 || step == 2);
    smr  = bsy && (k == 2 * H + 1);
    dn   = (k == 5 * H + 1);
    sel  = (k > H) ? new_sel : old_sel;
    return {iso, iso, crst, smr, smr, bsy, dn, sel};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse_req(logic [7:0] code);
    req_i = 1'b1;
    src_code_i = code;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset state", observed(), 8'b0);
  endtask

  // Full sequence with a per-cycle comparison; optionally a request mid-run.
  task automatic t_switch(logic [7:0] code, logic old_sel, logic new_sel, bit inject);
    pulse_req(code);
    for (int k = 1; k <= 5 * H + 2; k++) begin
      check($sformatf("R5 R6 R8 R9 cycle %0d", k), observed(),
            expect_at(k, old_sel, new_sel));
      if (inject && k == H + 2) begin
        req_i = 1'b1;
        src_code_i = old_sel ? 8'h21 : 8'h23;
      end else begin
        req_i = 1'b0;
      end
      @(negedge clk);
    end
    if (inject)
      check("R7 no restart after mid-run request",
            {busy_o, clk_sel_o}, {1'b0, new_sel});
  endtask

  // A request that must leave the block untouched.
  task automatic t_ignored(string tag, logic [7:0] code, logic idle, logic cur_sel);
    pair_idle_i = idle;
    pulse_req(code);
    for (int k = 1; k <= 3; k++) begin
      check(tag, observed(), {7'b0, cur_sel});
      @(negedge clk);
    end
    pair_idle_i = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored("R4 same source host", 8'h23, 1'b1, 1'b0);
    t_ignored("R2 unknown code 0x22", 8'h22, 1'b1, 1'b0);
    t_ignored("R3 partner busy", 8'h21, 1'b0, 1'b0);
    t_switch(8'h21, 1'b0, 1'b1, 1'b0);                  // R2 PLL code
    t_ignored("R4 same source pll", 8'h21, 1'b1, 1'b1);
    t_ignored("R2 unknown code 0x00", 8'h00, 1'b1, 1'b1);
    t_switch(8'h23, 1'b1, 1'b0, 1'b1);                  // R2 host code, R7
    t_ignored("R3 partner busy back", 8'h21, 1'b0, 1'b0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule